// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It decides whether a frame should be kept, based only on its 48-bit destination address. A start-of-frame pulse opens each frame. The address then arrives one byte per valid cycle, first byte on the wire first. While the bytes stream in, the block does three things: it compares them with a programmed node address, it checks for the all-ones broadcast address, and it runs them through a CRC-32 whose top bits index a 64-bit multicast hash table.

One cycle after the sixth address byte, the block raises a single-cycle decision strobe. The strobe carries an accept bit and a flag naming which kind of match caused acceptance: node address, hash filter or broadcast. A promiscuous input forces acceptance. A broadcast-disable input blocks broadcast frames unless promiscuous mode is on.

A multicast hit is only a hint, because several group addresses share one hash bin. Software must confirm that such a frame is really wanted.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, and before any frame has been received, `decision_o`, `accept_o` and all match flags are 0.
- R2: `decision_o` is high for exactly one cycle, in the cycle after the cycle in which the sixth address byte is taken.
- R3: Byte k on the wire (k = 0..5) is compared with `node_addr_i[8k+7:8k]`, and wire bit 0 of each byte is `byte_i[0]`. If the first bit received is 0 and all six bytes match, the frame is accepted with `phys_match_o` = 1.
- R4: A unicast address (`byte_i[0]` of the first byte is 0) that differs from the node address in any bit is rejected when promiscuous mode is off.
- R5: A group address that is not broadcast is hashed with CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each byte fed LSB first, no final inversion). Bits [31:26] of the result form an index. The frame is accepted with `lgc_match_o` = 1 exactly when `hash_filter_i[index]` is 1.
- R6: With `hash_filter_i` all zeros and promiscuous mode off, every non-broadcast group address is rejected.
- R7: The all-ones address is accepted with `bcast_match_o` = 1 when `bcast_dis_i` is 0. When `bcast_dis_i` is 1 and promiscuous mode is off, it is rejected.
- R8: With `promisc_i` = 1, every completed address is accepted.
- R9: A start-of-frame pulse discards any partly received address, so a frame cut short before six bytes produces no decision. A byte valid in the same cycle as the pulse is taken as byte 0.
- R10: Bytes after the sixth are ignored until the next start-of-frame pulse and produce no further decision.
- R11: At most one match flag is set at a time, and `accept_o` and the flags are 0 whenever `decision_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_valid_i | input | 1 | `byte_i` carries an address byte |
| byte_i | input | 8 | Address byte, wire bit 0 in bit 0 |
| node_addr_i | input | 48 | Node address, first wire byte in [7:0] |
| hash_filter_i | input | 64 | Multicast hash table |
| promisc_i | input | 1 | Accept every frame |
| bcast_dis_i | input | 1 | Reject broadcast unless promiscuous |
| decision_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted |
| phys_match_o | output | 1 | Node address matched |
| lgc_match_o | output | 1 | Hash filter bit hit |
| bcast_match_o | output | 1 | Broadcast accepted |

## Verification
The bench builds the block with its default parameters: six address bytes and a 64-entry hash table. These are the sizes at which the node-address byte order, the 6-bit hash index and the all-ones broadcast test can be checked against values the bench computes with its own bit-serial CRC model. For multicast, it computes the index of a chosen group address, then loads a table that has only that bin set, and next a table that has every bin except that one. This shows that the hash lookup, not just any table bit, decides the outcome. Truncated frames, bytes beyond the sixth, and a start-of-frame pulse that arrives together with byte 0 test how the byte counter restarts.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // one byte, LSB first, into an MSB-shifting register
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c, input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/daf_crc.sv
module daf_crc
  import daf_pkg::*;
#(
  parameter int unsigned HASH_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic [7:0]        data_i,
  output logic [HASH_W-1:0] idx_o
);
  logic [CRC_W-1:0] crc_q, base, nxt;

  assign base  = restart_i ? CRC_INIT : crc_q;
  assign nxt   = crc_byte(base, data_i);
  assign idx_o = nxt[CRC_W-1 -: HASH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= CRC_INIT;
    else if (step_i)    crc_q <= nxt;
    else if (restart_i) crc_q <= CRC_INIT;
  end
endmodule

// File: rtl/daf_track.sv
module daf_track #(
  parameter int unsigned NBYTES = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic                valid_i,
  input  logic [7:0]          byte_i,
  input  logic [8*NBYTES-1:0] node_addr_i,
  output logic                take_o,
  output logic                last_o,
  output logic                uni_ok_o,
  output logic                ones_o,
  output logic                group_o
);
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0]  cnt_q, eff_cnt;
  logic              ok_q, ones_q, group_q;
  logic              base_ok, base_ones;
  logic [NBYTES-1:0] lane_eq;
  logic              sel_eq;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lane_eq[k] = (byte_i == node_addr_i[8*k +: 8]);
  end

  assign eff_cnt   = sof_i ? '0 : cnt_q;
  assign base_ok   = sof_i | ok_q;
  assign base_ones = sof_i | ones_q;
  assign take_o    = valid_i && (eff_cnt < IDLE_C);
  assign last_o    = take_o && (eff_cnt == LAST_C);

  always_comb begin
    sel_eq = 1'b0;
    for (int k = 0; k < NBYTES; k++)
      if (eff_cnt == CNT_W'(k)) sel_eq = lane_eq[k];
  end

  assign uni_ok_o = base_ok & sel_eq;
  assign ones_o   = base_ones & (&byte_i);
  assign group_o  = (eff_cnt == '0) ? byte_i[0] : group_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= IDLE_C;
      ok_q    <= 1'b0;
      ones_q  <= 1'b0;
      group_q <= 1'b0;
    end else if (take_o) begin
      cnt_q   <= eff_cnt + 1'b1;
      ok_q    <= uni_ok_o;
      ones_q  <= ones_o;
      group_q <= group_o;
    end else if (sof_i) begin
      cnt_q   <= '0;
      ok_q    <= 1'b1;
      ones_q  <= 1'b1;
      group_q <= 1'b0;
    end
  end

  // R9: a start pulse leaves at most one byte counted
  a_r9_sof_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (cnt_q <= CNT_W'(1)));
  // R10: once idle, only a start pulse lets bytes in
  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == IDLE_C && !sof_i) |=> (cnt_q == IDLE_C));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned FILTER_BITS = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] node_addr_i,
  input  logic [FILTER_BITS-1:0]  hash_filter_i,
  input  logic                    promisc_i,
  input  logic                    bcast_dis_i,
  output logic                    decision_o,
  output logic                    accept_o,
  output logic                    phys_match_o,
  output logic                    lgc_match_o,
  output logic                    bcast_match_o
);
  localparam int unsigned HASH_W = $clog2(FILTER_BITS);

  logic              take, last, uni_ok, ones, group;
  logic [HASH_W-1:0] idx;
  logic              phys_d, lgc_d, bc_d, acc_d;

  daf_track #(.NBYTES(ADDR_BYTES)) u_track (
    .clk_i, .rst_ni, .sof_i,
    .valid_i (byte_valid_i),
    .byte_i,
    .node_addr_i,
    .take_o  (take),
    .last_o  (last),
    .uni_ok_o(uni_ok),
    .ones_o  (ones),
    .group_o (group)
  );

  daf_crc #(.HASH_W(HASH_W)) u_crc (
    .clk_i, .rst_ni,
    .restart_i(sof_i),
    .step_i   (take),
    .data_i   (byte_i),
    .idx_o    (idx)
  );

  assign phys_d = !group && uni_ok;
  assign bc_d   = ones && !bcast_dis_i;
  assign lgc_d  = group && !ones && hash_filter_i[idx];
  assign acc_d  = promisc_i || phys_d || lgc_d || bc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_o    <= 1'b0;
      accept_o      <= 1'b0;
      phys_match_o  <= 1'b0;
      lgc_match_o   <= 1'b0;
      bcast_match_o <= 1'b0;
    end else begin
      decision_o    <= last;
      accept_o      <= last && acc_d;
      phys_match_o  <= last && phys_d;
      lgc_match_o   <= last && lgc_d;
      bcast_match_o <= last && bc_d;
    end
  end

  a_r2_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> decision_o);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_o |=> !decision_o);
  a_r11_onehot_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phys_match_o, lgc_match_o, bcast_match_o}));
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_o |-> !(accept_o || phys_match_o || lgc_match_o || bcast_match_o));
  a_r8_promisc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && promisc_i) |=> accept_o);
  a_r6_zero_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hash_filter_i == '0) |=> !lgc_match_o);
  a_r3_phys_flag_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_match_o |-> accept_o);
endmodule

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  din = '0;
  logic [47:0] node = 48'h5634_1200_AB02;
  logic [63:0] filt = '0;
  logic        prom = 1'b0, bdis = 1'b0;
  logic        dec, acc, phy, lgc, bcm;

  int checks = 0, fails = 0, pulses = 0;
  logic [4:0] cap;

  always #4 clk = ~clk;

  dest_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(vld), .byte_i(din),
    .node_addr_i(node), .hash_filter_i(filt), .promisc_i(prom), .bcast_dis_i(bdis),
    .decision_o(dec), .accept_o(acc), .phys_match_o(phy), .lgc_match_o(lgc),
    .bcast_match_o(bcm)
  );

  always @(negedge clk) if (dec) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial model: feedback = top bit xor incoming bit
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb = c[31] ^ a[n];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  // sends n bytes of a; merged puts sof on byte 0; returns {dec,acc,phy,lgc,bcm} one cycle after
  task automatic send(input logic [47:0] a, input int n, input bit merged);
    @(negedge clk);
    sof = 1'b1;
    if (!merged) begin
      @(negedge clk);
      sof = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      vld = 1'b1;
      din = a[8*k +: 8];
      @(negedge clk);
      sof = 1'b0;
    end
    vld = 1'b0;
    cap = {dec, acc, phy, lgc, bcm};
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 outputs idle", {27'd0, dec, acc, phy, lgc, bcm}, 32'd0);
    repeat (3) @(negedge clk);
    check("R1 no pulse", pulses, 0);
  endtask

  task automatic t_unicast();
    send(node, 6, 1'b0);
    check("R3 unicast hit", {27'd0, cap}, 32'b11100);
    check("R2 single pulse", {31'd0, dec}, 32'd0);
    send({node[7:0], node[15:8], node[23:16], node[31:24], node[39:32], node[47:40]}, 6, 1'b0);
    check("R3 reversed byte order", {27'd0, cap}, 32'b10000);
    send(node ^ 48'h8000_0000_0000, 6, 1'b0);
    check("R4 last-bit mismatch", {27'd0, cap}, 32'b10000);
  endtask

  task automatic t_multicast();
    logic [47:0] g = 48'h3412_005E_0001;
    logic [5:0]  i = ref_idx(g);
    filt = 64'd1 << i;
    send(g, 6, 1'b0);
    check("R5 hash hit", {27'd0, cap}, 32'b11010);
    filt = ~(64'd1 << i);
    send(g, 6, 1'b0);
    check("R5 hash neighbours miss", {27'd0, cap}, 32'b10000);
    filt = '0;
    send(48'h0000_0000_0033, 6, 1'b0);
    check("R6 zero table rejects", {27'd0, cap}, 32'b10000);
  endtask

  task automatic t_broadcast();
    send('1, 6, 1'b0);
    check("R7 broadcast enabled", {27'd0, cap}, 32'b11001);
    bdis = 1'b1;
    send('1, 6, 1'b0);
    check("R7 broadcast disabled", {27'd0, cap}, 32'b10000);
  endtask

  task automatic t_promisc();
    prom = 1'b1;
    send('1, 6, 1'b0);
    check("R8 promisc broadcast", {27'd0, cap}, 32'b11000);
    send(48'h1111_2222_3300, 6, 1'b0);
    check("R8 promisc foreign unicast", {27'd0, cap}, 32'b11000);
    prom = 1'b0;
    bdis = 1'b0;
  endtask

  task automatic t_restart();
    int p0 = pulses;
    send(node, 3, 1'b0);
    check("R9 truncated no decision", pulses - p0, 0);
    send(node, 6, 1'b1);
    check("R9 merged sof frame", {27'd0, cap}, 32'b11100);
  endtask

  task automatic t_extra();
    int p0;
    send(node, 6, 1'b0);
    p0 = pulses;
    for (int k = 0; k < 8; k++) begin
      vld = 1'b1;
      din = node[7:0];
      @(negedge clk);
    end
    vld = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 trailing bytes ignored", pulses - p0, 0);
    check("R11 quiet outside pulse", {27'd0, dec, acc, phy, lgc, bcm}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_unicast();
    t_multicast();
    t_broadcast();
    t_promisc();
    t_restart();
    t_extra();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule